// File: doc/BRIEF.md
# Event-Driven Thread Context Scheduler

This block chooses which of several hardware thread contexts owns a single-issue execution engine. Exactly one context runs at a time. The running context gives up the engine only when it executes an explicit yield instruction. That instruction carries an event mask naming the event lines the context will sleep on. Each context keeps its own sleep mask and records which of those lines have already fired. A context becomes eligible again only once every line in its mask has fired. The next owner is chosen in rotating order, starting with the context after the one that ran last.

A yield costs at most one engine cycle. When the yield has no delay slot, the cycle after it is a bubble, and the output valid flag is low. When the yield has a filled delay slot, that cycle is used by the outgoing context for its delay-slot instruction, so no cycle is lost. In both cases the incoming context owns the engine from the second cycle after the yield. If no context is eligible, the scheduler idles with valid low. It resumes as soon as an event makes some context eligible.

The top-level state machine has four states. `AR_IDLE` means no owner. `AR_RUN` means a context is running. `AR_BUBBLE` is the aborted cycle after a yield without a delay slot. `AR_SLOT` is the delay-slot cycle after a yield that has one. The transitions are:
- `AR_RUN` goes to `AR_BUBBLE` or `AR_SLOT` on a yield.
- `AR_BUBBLE`, `AR_SLOT` and `AR_IDLE` each go to `AR_RUN` when some context is eligible, and to `AR_IDLE` when none is.
- Reset enters `AR_IDLE`.

Each context is in one of three states: `CS_WAIT` (sleeping), `CS_READY` (eligible) or `CS_RUN` (running).

Top module: `thread_ctx_sched`

## Requirements
- R1: Reset behaviour. While reset is held, `cur_valid` is 0. After reset, context 0 is eligible. Every other context k sleeps on the single event line k-1 (modulo the number of event lines). Context 0 owns the engine from the first clock edge after reset is released.
- R2: A yield (`sw_req` high) is taken only in the cycle where `cur_valid` is 1 and the state is `AR_RUN`. In every other cycle `sw_req` has no effect.
- R3: A yield with `sw_has_slot` = 0 makes `cur_valid` 0 in the following cycle. The next context is presented from the cycle after that.
- R4: A yield with `sw_has_slot` = 1 keeps `cur_valid` at 1 in the following cycle, with `cur_tid` still naming the yielding context. The next context is presented from the cycle after that.
- R5: A sleeping context becomes eligible only when every line set in its mask has been seen high. The lines may arrive in separate cycles. When it wakes, its mask and its record of seen lines are cleared.
- R6: An event line that is high while a context is not sleeping, or that is outside its mask, is not remembered for that context.
- R7: A yield with an all-zero mask leaves the yielding context eligible at once. It is still chosen only after every other eligible context in rotating order.
- R8: The next owner is the first eligible context found by searching upward from the context after the last owner, wrapping past the highest index.
- R9: When no context is eligible, `cur_valid` stays 0. An event line high in cycle N that wakes a context makes that context own the engine from cycle N+2.
- R10: Only an eligible context is ever started, and at most one context is running at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Running context executes a yield this cycle |
| sw_mask | input | EVT_W | Event lines the yielding context sleeps on |
| sw_has_slot | input | 1 | The yield has a filled delay slot |
| evt_sig | input | EVT_W | Event line pulses, one bit per line |
| cur_tid | output | TID_W | Index of the context owning the engine |
| cur_valid | output | 1 | The engine issues for `cur_tid` this cycle |

## Verification
The scheduler is driven through yields both with and without a delay slot. This separates a bubble cycle from a delay-slot cycle, and both from the cycle in which the new owner first appears. Masks of one line, of two lines that arrive in different cycles, and all-zero yield masks show the difference between a partial wake, a full wake and a self-yield that must defer to others. Events sent to a context that is not sleeping, and a yield request while idle, test whether the block remembers input it must ignore. The order of hand-offs across several wraps of the context index exposes any error in where the rotating search starts.

// File: rtl/thread_ctx_pkg.sv
package thread_ctx_pkg;

    typedef enum logic [1:0] {
        AR_IDLE,
        AR_RUN,
        AR_BUBBLE,
        AR_SLOT
    } arb_st_e;

    typedef enum logic [1:0] {
        CS_WAIT,
        CS_READY,
        CS_RUN
    } ctx_st_e;

endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
    import thread_ctx_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [EVT_W-1:0] arm_mask,
    input  logic             launch,
    input  logic [EVT_W-1:0] evt_sig,
    output logic             ready,
    output logic             running
);

    localparam int START_BIT = (IDX == 0) ? 0 : (IDX - 1) % EVT_W;
    localparam logic [EVT_W-1:0] ONE_HOT = {{(EVT_W-1){1'b0}}, 1'b1};
    localparam logic [EVT_W-1:0] START_MASK = (IDX == 0) ? '0 : (ONE_HOT << START_BIT);

    ctx_st_e          st_q;
    logic [EVT_W-1:0] mask_q;
    logic [EVT_W-1:0] seen_q;
    logic [EVT_W-1:0] got;

    assign got = seen_q | (evt_sig & mask_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= (IDX == 0) ? CS_READY : CS_WAIT;
            mask_q <= START_MASK;
            seen_q <= '0;
        end else if (arm) begin
            st_q   <= (arm_mask == '0) ? CS_READY : CS_WAIT;
            mask_q <= arm_mask;
            seen_q <= '0;
        end else if (launch) begin
            st_q <= CS_RUN;
        end else if (st_q == CS_WAIT) begin
            if (got == mask_q) begin
                st_q   <= CS_READY;
                mask_q <= '0;
                seen_q <= '0;
            end else begin
                seen_q <= got;
            end
        end
    end

    assign ready   = (st_q == CS_READY);
    assign running = (st_q == CS_RUN);

    AST_LAUNCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (st_q == CS_READY)); // R10
    AST_ARM_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (st_q == CS_RUN)); // R2
    AST_NO_PARTIAL_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_WAIT && !arm && ((seen_q | evt_sig) & mask_q) != mask_q) |=> (st_q == CS_WAIT)); // R5

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [TID_W-1:0] base,
    output logic             gnt_vld,
    output logic [TID_W-1:0] gnt_idx
);

    function automatic logic [TID_W-1:0] wrap_add(input logic [TID_W-1:0] b, input int o);
        int s;
        s = int'(b) + o;
        if (s >= N) s = s - N;
        return TID_W'(s);
    endfunction

    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = base;
        for (int off = 1; off <= N; off++) begin
            if (!gnt_vld && req[wrap_add(base, off)]) begin
                gnt_vld = 1'b1;
                gnt_idx = wrap_add(base, off);
            end
        end
    end

endmodule

// File: rtl/thread_ctx_sched.sv
module thread_ctx_sched
    import thread_ctx_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int EVT_W   = 8,
    localparam int TID_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic [EVT_W-1:0] sw_mask,
    input  logic             sw_has_slot,
    input  logic [EVT_W-1:0] evt_sig,
    output logic [TID_W-1:0] cur_tid,
    output logic             cur_valid
);

    arb_st_e            st_q, st_d;
    logic [TID_W-1:0]   tid_q, tid_d;
    logic [NUM_CTX-1:0] ready, running, arm, launch;
    logic               pick_vld;
    logic [TID_W-1:0]   pick_idx;
    logic               take_sw, start_any;

    rr_pick #(.N(NUM_CTX), .TID_W(TID_W)) u_pick (
        .req     (ready),
        .base    (tid_q),
        .gnt_vld (pick_vld),
        .gnt_idx (pick_idx)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        assign arm[g]    = take_sw && (tid_q == TID_W'(g));
        assign launch[g] = start_any && (pick_idx == TID_W'(g));

        ctx_slot #(.IDX(g), .EVT_W(EVT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (arm[g]),
            .arm_mask (sw_mask),
            .launch   (launch[g]),
            .evt_sig  (evt_sig),
            .ready    (ready[g]),
            .running  (running[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        tid_d     = tid_q;
        take_sw   = 1'b0;
        start_any = 1'b0;
        unique case (st_q)
            AR_RUN: begin
                if (sw_req) begin
                    take_sw = 1'b1;
                    st_d    = sw_has_slot ? AR_SLOT : AR_BUBBLE;
                end
            end
            AR_IDLE, AR_BUBBLE, AR_SLOT: begin
                if (pick_vld) begin
                    start_any = 1'b1;
                    tid_d     = pick_idx;
                    st_d      = AR_RUN;
                end else begin
                    st_d = AR_IDLE;
                end
            end
            default: st_d = AR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= AR_IDLE;
            tid_q <= TID_W'(NUM_CTX - 1);
        end else begin
            st_q  <= st_d;
            tid_q <= tid_d;
        end
    end

    always_comb begin
        cur_valid = (st_q == AR_RUN) || (st_q == AR_SLOT);
        cur_tid   = tid_q;
    end

    AST_ONE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(running)); // R10
    AST_BUBBLE_AFTER_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && st_q == AR_RUN && sw_req && !sw_has_slot) |=> !cur_valid); // R3
    AST_SLOT_KEEPS_TID: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_valid && st_q == AR_RUN && sw_req && sw_has_slot) |=> (cur_valid && cur_tid == $past(cur_tid))); // R4
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_valid && ready == '0) |=> !cur_valid); // R9

endmodule

// File: tb/sim_thread_ctx_sched.sv
module sim_thread_ctx_sched;

    localparam int NC = 4;
    localparam int EW = 8;

    typedef struct {
        bit         v;
        logic [1:0] t;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sw_req;
    logic [EW-1:0] sw_mask;
    logic          sw_has_slot;
    logic [EW-1:0] evt_sig;
    logic [1:0]    cur_tid;
    logic          cur_valid;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    thread_ctx_sched #(.NUM_CTX(NC), .EVT_W(EW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_req      (sw_req),
        .sw_mask     (sw_mask),
        .sw_has_slot (sw_has_slot),
        .evt_sig     (evt_sig),
        .cur_tid     (cur_tid),
        .cur_valid   (cur_valid)
    );

    task automatic cyc(input bit sw, input logic [EW-1:0] m, input bit slot,
                       input logic [EW-1:0] ev, input bit xv, input logic [1:0] xt,
                       input string tag);
        exp_t e;
        @(negedge clk);
        sw_req      = sw;
        sw_mask     = m;
        sw_has_slot = slot;
        evt_sig     = ev;
        e.v = xv; e.t = xt; e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (cur_valid !== e.v || (e.v && cur_tid !== e.t)) begin
                    n_fails++;
                    $display("FAIL %s: valid=%0d tid=%0d expected valid=%0d tid=%0d",
                             e.tag, cur_valid, cur_tid, e.v, e.t);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_req = 1'b0; sw_mask = '0; sw_has_slot = 1'b0; evt_sig = '0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (cur_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 reset: valid=%0d expected valid=0", cur_valid);
        end
        rst_n = 1'b1;
        // context 1 sleeps on line 0, context 2 on line 1, context 3 on line 2
        cyc(0, 8'h00, 0, 8'h00, 1, 2'd0, "R1 ctx0 owns after reset");
        cyc(0, 8'h00, 0, 8'h11, 1, 2'd0, "R6 wake ctx1, line4 while ctx0 runs");
        cyc(0, 8'h00, 0, 8'h06, 1, 2'd0, "R5 wake ctx2 ctx3");
        cyc(1, 8'h10, 0, 8'h00, 0, 2'd0, "R3 bubble after yield");
        cyc(0, 8'h00, 0, 8'h00, 1, 2'd1, "R8 R10 next after ctx0");
        cyc(1, 8'h00, 1, 8'h00, 1, 2'd1, "R4 delay slot keeps ctx1");
        cyc(0, 8'h00, 0, 8'h00, 1, 2'd2, "R7 yielder deferred");
        cyc(1, 8'h60, 0, 8'h00, 0, 2'd0, "R3 bubble two-line mask");
        cyc(0, 8'h00, 0, 8'h20, 1, 2'd3, "R8 ctx3 next");
        cyc(1, 8'h80, 0, 8'h00, 0, 2'd0, "R3 bubble");
        cyc(0, 8'h00, 0, 8'h00, 1, 2'd1, "R8 wrap to ctx1");
        cyc(1, 8'h01, 1, 8'h00, 1, 2'd1, "R4 slot cycle");
        cyc(0, 8'h00, 0, 8'h00, 0, 2'd0, "R9 R5 R6 none eligible");
        cyc(1, 8'h00, 0, 8'h00, 0, 2'd0, "R2 yield while idle");
        cyc(0, 8'h00, 0, 8'h00, 0, 2'd0, "R2 idle yield ignored");
        cyc(0, 8'h00, 0, 8'h40, 0, 2'd0, "R9 R5 second line lands");
        cyc(0, 8'h00, 0, 8'h00, 1, 2'd2, "R9 ctx2 owns two cycles later");
        cyc(0, 8'h00, 0, 8'h11, 1, 2'd2, "R5 wake ctx0 ctx1");
        cyc(1, 8'h02, 0, 8'h00, 0, 2'd0, "R3 bubble");
        cyc(0, 8'h00, 0, 8'h00, 1, 2'd0, "R8 wrap ctx3 sleeping to ctx0");
        cyc(1, 8'h00, 0, 8'h00, 0, 2'd0, "R7 zero-mask yield bubble");
        cyc(0, 8'h00, 0, 8'h00, 1, 2'd1, "R7 R8 ctx1 before self");
        cyc(0, 8'h00, 0, 8'h80, 1, 2'd1, "R5 wake ctx3");
        cyc(1, 8'h00, 1, 8'h00, 1, 2'd1, "R4 slot with zero mask");
        cyc(0, 8'h00, 0, 8'h00, 1, 2'd3, "R8 ctx3 after ctx1");
        @(negedge clk);
        sw_req = 1'b0; sw_mask = '0; sw_has_slot = 1'b0; evt_sig = '0;
        @(posedge clk);
        #2;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule